// File: doc/BRIEF.md
# Coalescing Miss Fill Buffer

This block tracks outstanding first-level data misses. A load that misses presents its byte address and a load tag. If no tracked line matches, the block claims a free slot, records the line address and sends one request to the next level. If a slot already tracks that line, the load joins that slot's list of waiters and no second request goes out. The next level answers with the line as a burst of 8-byte beats addressed by slot number. Once the last beat is in, the slot hands each waiter its tag and the 8-byte word it asked for, one per cycle, then frees itself.

A full buffer pushes back on the miss port. The same happens when a matching slot has no room left for another waiter. Line matching covers slots that are still filling and slots that are already handing out data. A load that arrives together with the last beat of a fill, or while a slot is serving its waiters, therefore joins that slot and triggers no new request.

Top module: `miss_fill_buffer`

## Requirements
- R1: While reset is held and in the first cycle after it, `miss_ready_o` is 1, `req_valid_o` is 0 and `resp_valid_o` is 0.
- R2: An accepted miss whose line address (`miss_addr_i[31:6]`) matches no busy slot claims the lowest-numbered free slot. That slot raises exactly one request with `req_line_o` equal to the line address and `req_id_o` equal to the slot number.
- R3: An accepted miss whose line address matches a busy slot joins that slot as a waiter and causes no further request. At most one slot tracks any given line.
- R4: A slot holds at most 4 waiters. A miss that matches a slot already holding 4 waiters is stalled with `miss_ready_o` low until that slot frees.
- R5: When all 16 slots are busy, a miss to an untracked line is stalled with `miss_ready_o` low. A miss matching a busy slot with room is still accepted.
- R6: A fill arrives as 8 beats on `fill_valid_i` for slot `fill_id_i`. Beat k carries bytes 8k to 8k+7 of the line. The slot completes on the eighth beat, and its first response can appear in the next cycle.
- R7: A completed slot returns each waiter once, in join order, one response per cycle. Each response carries the waiter's tag and the beat selected by `miss_addr_i[5:3]` of that waiter. When several slots are complete, the lowest-numbered one is served first.
- R8: A slot frees in the cycle after its last waiter is served, unless a new miss joined it in that same cycle. A miss arriving in the cycle of the final fill beat joins the slot.
- R9: While `req_valid_o` is high and `req_ready_i` is low, `req_valid_o`, `req_id_o` and `req_line_o` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request present |
| miss_ready_o | output | 1 | Miss accepted this cycle when valid |
| miss_addr_i | input | 32 | Byte address of the missing load |
| miss_tag_i | input | 6 | Load tag returned with the data |
| req_valid_o | output | 1 | Downstream line request present |
| req_ready_i | input | 1 | Downstream takes the request |
| req_line_o | output | 26 | Line address requested |
| req_id_o | output | 4 | Slot that will receive the fill |
| fill_valid_i | input | 1 | Fill beat present |
| fill_id_i | input | 4 | Slot the beat belongs to |
| fill_data_i | input | 64 | Beat data |
| resp_valid_o | output | 1 | Load response present |
| resp_tag_o | output | 6 | Tag of the load served |
| resp_data_o | output | 64 | 8-byte word for that load |

## Verification
On every cycle the assertions check several invariants. No two slots track the same line, and a slot never takes a fifth waiter. Fill beats only reach slots that are waiting and have sent their request. A slot becomes complete on its eighth beat and frees after its final response. A stalled request holds steady, and a request that was just sent is not repeated. Other properties need whole scenarios, which only the bench can show. These are the coalescing down to a single request, the stall when all slots or all waiter places are used, the order and data of responses, and a load joining on the final beat.

// File: rtl/mfb_pkg.sv
package mfb_pkg;
  typedef enum logic [1:0] {
    E_IDLE = 2'd0,
    E_WAIT = 2'd1,
    E_DONE = 2'd2
  } ent_state_e;
endpackage

// File: rtl/mfb_pick.sv
module mfb_pick #(
  parameter  int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest set index wins
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/mfb_entry.sv
module mfb_entry
  import mfb_pkg::*;
#(
  parameter  int LINE_W  = 26,
  parameter  int TAG_W   = 6,
  parameter  int WAITERS = 4,
  parameter  int BEATS   = 8,
  parameter  int DATA_W  = 64,
  localparam int WI      = $clog2(WAITERS),
  localparam int CW      = $clog2(WAITERS + 1),
  localparam int BI      = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              attach_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [BI-1:0]     word_i,
  input  logic              req_sent_i,
  input  logic              fill_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              serve_i,
  output logic              busy_o,
  output logic              match_o,
  output logic              full_o,
  output logic              need_req_o,
  output logic              has_resp_o,
  output logic [LINE_W-1:0] line_o,
  output logic [TAG_W-1:0]  resp_tag_o,
  output logic [DATA_W-1:0] resp_data_o
);
  ent_state_e        state_q;
  logic [LINE_W-1:0] line_q;
  logic              sent_q;
  logic [BI-1:0]     beat_q;
  logic [CW-1:0]     n_q;
  logic [CW-1:0]     sidx_q;
  logic [DATA_W-1:0] data_q [BEATS];
  logic [TAG_W-1:0]  tag_q  [WAITERS];
  logic [BI-1:0]     word_q [WAITERS];
  logic              last_serve;
  logic              last_beat;

  assign busy_o      = (state_q != E_IDLE);
  assign match_o     = busy_o && (line_q == line_i);
  assign full_o      = (n_q == CW'(WAITERS));
  assign need_req_o  = (state_q == E_WAIT) && !sent_q;
  assign has_resp_o  = (state_q == E_DONE) && (sidx_q < n_q);
  assign line_o      = line_q;
  assign resp_tag_o  = tag_q[sidx_q[WI-1:0]];
  assign resp_data_o = data_q[word_q[sidx_q[WI-1:0]]];
  assign last_serve  = serve_i && ((sidx_q + CW'(1)) == n_q);
  assign last_beat   = (beat_q == BI'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= E_IDLE;
      line_q  <= '0;
      sent_q  <= 1'b0;
      beat_q  <= '0;
      n_q     <= '0;
      sidx_q  <= '0;
    end else if (alloc_i) begin
      state_q <= E_WAIT;
      line_q  <= line_i;
      sent_q  <= 1'b0;
      beat_q  <= '0;
      n_q     <= CW'(1);
      sidx_q  <= '0;
    end else begin
      if (req_sent_i) sent_q <= 1'b1;
      if (fill_i) begin
        beat_q <= beat_q + BI'(1);
        if (last_beat) state_q <= E_DONE;
      end
      if (serve_i) sidx_q <= sidx_q + CW'(1);
      if (last_serve && !attach_i) state_q <= E_IDLE;
      if (attach_i) n_q <= n_q + CW'(1);
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk_i) begin
    if (alloc_i) begin
      tag_q[0]  <= tag_i;
      word_q[0] <= word_i;
    end else if (attach_i) begin
      tag_q[n_q[WI-1:0]]  <= tag_i;
      word_q[n_q[WI-1:0]] <= word_i;
    end
    if (fill_i) data_q[beat_q] <= fill_data_i;
  end

  p_alloc_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (state_q == E_IDLE));
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attach_i |-> (n_q < CW'(WAITERS)));
  p_fill_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> ((state_q == E_WAIT) && sent_q));
  p_done_on_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && last_beat) |=> (state_q == E_DONE));
  p_free_after_serve_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_serve && !attach_i && !alloc_i) |=> (state_q == E_IDLE));
endmodule

// File: rtl/miss_fill_buffer.sv
module miss_fill_buffer
  import mfb_pkg::*;
#(
  parameter  int ADDR_W     = 32,
  parameter  int TAG_W      = 6,
  parameter  int ENTRIES    = 16,
  parameter  int WAITERS    = 4,
  parameter  int LINE_BYTES = 64,
  parameter  int BEAT_BYTES = 8,
  localparam int DATA_W     = BEAT_BYTES * 8,
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int BOFF       = $clog2(BEAT_BYTES),
  localparam int LINE_W     = ADDR_W - OFF_W,
  localparam int BI         = $clog2(BEATS),
  localparam int IW         = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  output logic              miss_ready_o,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic [TAG_W-1:0]  miss_tag_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [LINE_W-1:0] req_line_o,
  output logic [IW-1:0]     req_id_o,
  input  logic              fill_valid_i,
  input  logic [IW-1:0]     fill_id_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              resp_valid_o,
  output logic [TAG_W-1:0]  resp_tag_o,
  output logic [DATA_W-1:0] resp_data_o
);
  logic [LINE_W-1:0] miss_line;
  logic [BI-1:0]     miss_word;
  logic              unused_low;

  logic [ENTRIES-1:0] busy_vec, match_vec, full_vec, need_vec, rdy_vec;
  logic [ENTRIES-1:0] alloc_vec, attach_vec, sent_vec, fill_vec, serve_vec;
  logic [LINE_W-1:0]  line_arr [ENTRIES];
  logic [TAG_W-1:0]   tag_arr  [ENTRIES];
  logic [DATA_W-1:0]  data_arr [ENTRIES];

  logic          hit, hit_full, any_free, accept;
  logic [IW-1:0] free_idx;
  logic          need_any;
  logic [IW-1:0] need_idx;
  logic          resp_any;
  logic [IW-1:0] resp_idx;
  logic          lock_q;
  logic [IW-1:0] lock_id_q;

  assign miss_line  = miss_addr_i[ADDR_W-1:OFF_W];
  assign miss_word  = miss_addr_i[OFF_W-1:BOFF];
  assign unused_low = ^miss_addr_i[BOFF-1:0];

  assign hit          = |match_vec;
  assign hit_full     = |(match_vec & full_vec);
  assign miss_ready_o = hit ? !hit_full : any_free;
  assign accept       = miss_valid_i && miss_ready_o;

  mfb_pick #(.N(ENTRIES)) i_pick_free (
    .vec_i(~busy_vec), .found_o(any_free), .idx_o(free_idx));
  mfb_pick #(.N(ENTRIES)) i_pick_req (
    .vec_i(need_vec), .found_o(need_any), .idx_o(need_idx));
  mfb_pick #(.N(ENTRIES)) i_pick_resp (
    .vec_i(rdy_vec), .found_o(resp_any), .idx_o(resp_idx));

  // a stalled request keeps its slot even if a lower one becomes eligible
  assign req_valid_o = lock_q || need_any;
  assign req_id_o    = lock_q ? lock_id_q : need_idx;
  assign req_line_o  = line_arr[req_id_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q    <= 1'b0;
      lock_id_q <= '0;
    end else begin
      lock_q    <= req_valid_o && !req_ready_i;
      lock_id_q <= req_id_o;
    end
  end

  assign resp_valid_o = resp_any;
  assign resp_tag_o   = tag_arr[resp_idx];
  assign resp_data_o  = data_arr[resp_idx];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign alloc_vec[e]  = accept && !hit && (free_idx == IW'(e));
    assign attach_vec[e] = accept && match_vec[e];
    assign sent_vec[e]   = req_valid_o && req_ready_i && (req_id_o == IW'(e));
    assign fill_vec[e]   = fill_valid_i && (fill_id_i == IW'(e));
    assign serve_vec[e]  = resp_any && (resp_idx == IW'(e));

    mfb_entry #(
      .LINE_W (LINE_W),
      .TAG_W  (TAG_W),
      .WAITERS(WAITERS),
      .BEATS  (BEATS),
      .DATA_W (DATA_W)
    ) i_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alloc_i    (alloc_vec[e]),
      .attach_i   (attach_vec[e]),
      .line_i     (miss_line),
      .tag_i      (miss_tag_i),
      .word_i     (miss_word),
      .req_sent_i (sent_vec[e]),
      .fill_i     (fill_vec[e]),
      .fill_data_i(fill_data_i),
      .serve_i    (serve_vec[e]),
      .busy_o     (busy_vec[e]),
      .match_o    (match_vec[e]),
      .full_o     (full_vec[e]),
      .need_req_o (need_vec[e]),
      .has_resp_o (rdy_vec[e]),
      .line_o     (line_arr[e]),
      .resp_tag_o (tag_arr[e]),
      .resp_data_o(data_arr[e])
    );
  end

  p_single_owner_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));
  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_id_o) && $stable(req_line_o)));
  p_no_repeat_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> !(req_valid_o && (req_id_o == $past(req_id_o))));
  p_stall_when_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&busy_vec) && !hit) |-> !accept);
endmodule

// File: tb/test_miss_fill_buffer.sv
`timescale 1ns/100ps
module test_miss_fill_buffer;
  localparam int E = 16;
  localparam int W = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid_i = 1'b0;
  logic        miss_ready_o;
  logic [31:0] miss_addr_i = '0;
  logic [5:0]  miss_tag_i = '0;
  logic        req_valid_o;
  logic        req_ready_i = 1'b0;
  logic [25:0] req_line_o;
  logic [3:0]  req_id_o;
  logic        fill_valid_i = 1'b0;
  logic [3:0]  fill_id_i = '0;
  logic [63:0] fill_data_i = '0;
  logic        resp_valid_o;
  logic [5:0]  resp_tag_o;
  logic [63:0] resp_data_o;

  miss_fill_buffer i_miss_fill_buffer (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(miss_valid_i), .miss_ready_o(miss_ready_o),
    .miss_addr_i(miss_addr_i), .miss_tag_i(miss_tag_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_line_o(req_line_o), .req_id_o(req_id_o),
    .fill_valid_i(fill_valid_i), .fill_id_i(fill_id_i), .fill_data_i(fill_data_i),
    .resp_valid_o(resp_valid_o), .resp_tag_o(resp_tag_o), .resp_data_o(resp_data_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, n_req = 0;
  bit finished = 0;
  int tag_seen [64];

  // reference model state
  int          m_st   [E];
  logic [25:0] m_line [E];
  bit          m_sent [E];
  int          m_beat [E];
  int          m_sidx [E];
  logic [63:0] m_data [E][8];
  int          m_tag  [E][$];
  int          m_word [E][$];
  bit          m_lock = 0;
  int          m_lock_id = 0;

  // responder state
  int          rq_id [$];
  logic [25:0] rq_line [$];
  int          cur_id = -1, cur_beat = 0;
  logic [25:0] cur_line = '0;
  bit          fill_pause = 0, hold_last = 0, rr_alt = 0;

  function automatic logic [63:0] fd(logic [25:0] l, int b);
    return {6'h2A, l, 24'hBEA000, 5'h0, b[2:0]};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  // downstream responder
  always @(posedge clk) begin
    #1.5;
    if (!rst_n) begin
      req_ready_i  = 1'b0;
      fill_valid_i = 1'b0;
    end else begin
      req_ready_i  = rr_alt ? cyc[0] : 1'b1;
      fill_valid_i = 1'b0;
      if (cur_id < 0 && rq_id.size() > 0 && !fill_pause) begin
        cur_id   = rq_id.pop_front();
        cur_line = rq_line.pop_front();
        cur_beat = 0;
      end
      if (cur_id >= 0 && !fill_pause && !(hold_last && cur_beat == 7)) begin
        fill_valid_i = 1'b1;
        fill_id_i    = cur_id[3:0];
        fill_data_i  = fd(cur_line, cur_beat);
        cur_beat++;
        if (cur_beat == 8) cur_id = -1;
      end
    end
  end

  // cycle compare and model step
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int hit_e, free_e, req_e, rsp_e;
      bit exp_rdy;
      logic [25:0] ml;
      ml = miss_addr_i[31:6];
      hit_e = -1; free_e = -1; req_e = -1; rsp_e = -1;
      for (int e = E - 1; e >= 0; e--) begin
        if (m_st[e] != 0 && m_line[e] == ml) hit_e = e;
        if (m_st[e] == 0) free_e = e;
        if (m_st[e] == 1 && !m_sent[e]) req_e = e;
        if (m_st[e] == 2 && m_sidx[e] < m_tag[e].size()) rsp_e = e;
      end
      if (m_lock) req_e = m_lock_id;
      exp_rdy = (hit_e >= 0) ? (m_tag[hit_e].size() < W) : (free_e >= 0);

      chk("R4/R5", "miss_ready_o", 64'(miss_ready_o), 64'(exp_rdy));
      chk("R2", "req_valid_o", 64'(req_valid_o), 64'(req_e >= 0));
      if (req_e >= 0) begin
        chk("R9", "req_id_o", 64'(req_id_o), 64'(req_e));
        chk("R2", "req_line_o", 64'(req_line_o), 64'(m_line[req_e]));
      end
      chk("R6", "resp_valid_o", 64'(resp_valid_o), 64'(rsp_e >= 0));
      if (rsp_e >= 0) begin
        chk("R7", "resp_tag_o", 64'(resp_tag_o), 64'(m_tag[rsp_e][m_sidx[rsp_e]]));
        chk("R7", "resp_data_o", resp_data_o,
            m_data[rsp_e][m_word[rsp_e][m_sidx[rsp_e]]]);
        tag_seen[resp_tag_o]++;
      end

      if (req_e >= 0 && req_ready_i) begin
        m_sent[req_e] = 1;
        rq_id.push_back(req_e);
        rq_line.push_back(m_line[req_e]);
        n_req++;
      end
      m_lock    = (req_e >= 0) && !req_ready_i;
      m_lock_id = req_e;
      if (fill_valid_i) begin
        int f;
        f = int'(fill_id_i);
        m_data[f][m_beat[f]] = fill_data_i;
        m_beat[f]++;
        if (m_beat[f] == 8) m_st[f] = 2;
      end
      if (rsp_e >= 0) m_sidx[rsp_e]++;
      if (miss_valid_i && exp_rdy) begin
        if (hit_e >= 0) begin
          m_tag[hit_e].push_back(int'(miss_tag_i));
          m_word[hit_e].push_back(int'(miss_addr_i[5:3]));
        end else begin
          m_st[free_e]   = 1;
          m_line[free_e] = ml;
          m_sent[free_e] = 0;
          m_beat[free_e] = 0;
          m_sidx[free_e] = 0;
          m_tag[free_e].delete();
          m_word[free_e].delete();
          m_tag[free_e].push_back(int'(miss_tag_i));
          m_word[free_e].push_back(int'(miss_addr_i[5:3]));
        end
      end
      if (rsp_e >= 0 && m_sidx[rsp_e] == m_tag[rsp_e].size()) m_st[rsp_e] = 0;
    end
  end

  // called at posedge+1, returns at posedge+1 after the accepting edge
  task automatic miss(int line, int word, int tag);
    bit acc;
    miss_valid_i = 1'b1;
    miss_addr_i  = {line[25:0], word[2:0], 3'b000};
    miss_tag_i   = tag[5:0];
    acc = 0;
    while (!acc) begin
      @(negedge clk); #0.5;
      acc = miss_ready_o;
      @(posedge clk); #1;
    end
    miss_valid_i = 1'b0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic drain();
    bit busy;
    int guard;
    guard = 0;
    busy = 1;
    while (busy && guard < 3000) begin
      tick(1);
      guard++;
      busy = (rq_id.size() != 0) || (cur_id >= 0);
      for (int e = 0; e < E; e++) if (m_st[e] != 0) busy = 1;
    end
    chk("R8", "drained to idle", 64'(busy), 64'(0));
  endtask

  initial begin
    int r0, lcg;
    for (int e = 0; e < E; e++) begin
      m_st[e] = 0; m_sent[e] = 0; m_beat[e] = 0; m_sidx[e] = 0; m_line[e] = '0;
    end
    for (int t = 0; t < 64; t++) tag_seen[t] = 0;

    // R1 reset state
    tick(3);
    @(negedge clk); #1;
    chk("R1", "miss_ready_o in reset", 64'(miss_ready_o), 64'(1));
    chk("R1", "req_valid_o in reset", 64'(req_valid_o), 64'(0));
    chk("R1", "resp_valid_o in reset", 64'(resp_valid_o), 64'(0));
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "miss_ready_o after reset", 64'(miss_ready_o), 64'(1));
    chk("R1", "req_valid_o after reset", 64'(req_valid_o), 64'(0));
    chk("R1", "resp_valid_o after reset", 64'(resp_valid_o), 64'(0));
    @(posedge clk); #1;

    // R2 single miss
    r0 = n_req;
    miss(26'h0123, 3, 5);
    drain();
    chk("R2", "one request for single miss", 64'(n_req - r0), 64'(1));
    chk("R7", "tag 5 served once", 64'(tag_seen[5]), 64'(1));

    // R3 coalescing, R4 waiter cap
    fill_pause = 1;
    r0 = n_req;
    miss(26'h0200, 0, 10);
    miss(26'h0200, 7, 11);
    miss(26'h0200, 2, 12);
    miss(26'h0200, 2, 13);
    miss_valid_i = 1'b1;
    miss_addr_i  = {26'h0200, 3'd4, 3'b000};
    miss_tag_i   = 6'd14;
    tick(4);
    @(negedge clk); #0.5;
    chk("R4", "fifth waiter stalled", 64'(miss_ready_o), 64'(0));
    @(posedge clk); #1;
    fill_pause = 0;
    miss(26'h0200, 4, 14);
    drain();
    chk("R3", "two requests for five loads on one line", 64'(n_req - r0), 64'(2));
    chk("R7", "tag 13 served once", 64'(tag_seen[13]), 64'(1));
    chk("R7", "tag 14 served once", 64'(tag_seen[14]), 64'(1));

    // R5 all slots busy
    fill_pause = 1;
    for (int i = 0; i < E; i++) miss(26'h1000 + i, i % 8, 20 + i);
    miss_valid_i = 1'b1;
    miss_addr_i  = {26'h2000, 3'd1, 3'b000};
    miss_tag_i   = 6'd40;
    tick(3);
    @(negedge clk); #0.5;
    chk("R5", "new line stalled when full", 64'(miss_ready_o), 64'(0));
    @(posedge clk); #1;
    miss_addr_i = {26'h1000, 3'd6, 3'b000};
    miss_tag_i  = 6'd41;
    @(negedge clk); #0.5;
    chk("R5", "matching line accepted when full", 64'(miss_ready_o), 64'(1));
    @(posedge clk); #1;
    miss_valid_i = 1'b0;
    fill_pause = 0;
    miss(26'h2000, 1, 40);
    drain();
    chk("R5", "stalled miss served after free", 64'(tag_seen[40]), 64'(1));

    // R8 join on final beat
    r0 = n_req;
    hold_last = 1;
    miss(26'h3300, 5, 50);
    while (!(cur_id >= 0 && cur_beat == 7)) tick(1);
    hold_last = 0;
    miss(26'h3300, 1, 51);
    drain();
    chk("R8", "final-beat join adds no request", 64'(n_req - r0), 64'(1));
    chk("R8", "final-beat joiner served", 64'(tag_seen[51]), 64'(1));

    // mixed traffic with stalling downstream (R6, R7, R9)
    rr_alt = 1;
    lcg = 7;
    for (int i = 0; i < 400; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      if (lcg[4:3] == 2'b00) tick(1 + lcg[6:5]);
      else miss(26'h4000 + (lcg[12:9] % 6), lcg[15:13], lcg[21:16]);
    end
    drain();
    rr_alt = 0;
    tick(2);
    summary();
  end
endmodule